// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines (96 by default, 128 at most) in groups of 32. Software enables each line through a mask bit and can also raise any line itself through a software trigger. Every line has its own six-bit priority and a routing bit that sends it to either the normal or the fast interrupt output. Each output has an arbiter that picks one winner among the lines routed to it.

When an output is idle and at least one line routed to it is pending, the controller raises that output and records the winner's number. The line and the number then stay frozen until software writes the acknowledge bit for that output. The controller then drops the output for one cycle and arbitrates again. All control and status goes through a 32-bit register bus with single-cycle writes and combinational reads. A soft reset returns every register to its reset value.

Top module: `irqc_top`

## Requirements
- R1: The revision word at byte address 0x00 reads the major revision (default 2) in bits 7:4 and the minor revision (default 1) in bits 3:0, with all other bits zero.
- R2: After reset, every mask bit reads 1, every software trigger reads 0 and every level word reads 0. Both outputs are low and both active-number words read 0x80.
- R3: A line is pending when its input or its software trigger is 1 and its mask bit is 0. A masked line never raises an output. In each group, the word at +0x04 writes the mask directly, +0x08 clears the mask bits written as 1, and +0x0C sets them.
- R4: In each group, writing 1s to +0x10 sets those software triggers and writing 1s to +0x14 clears them. Both words read back the trigger bits.
- R5: Each line has a level word at 0x100 + 4*n. Bit 0 routes the line to the fast output when 1. Bits 7:2 hold its priority. In each group, +0x18 reads the pending lines routed to the normal output and +0x1C those routed to the fast output.
- R6: Each output's winner is the pending line with the smallest priority value. When several lines share that value, the lowest line number wins.
- R7: An idle output rises one clock edge after a winner exists. Its active-number word (0x40 normal, 0x44 fast) then reads the winner number with bit 7 = 0. It reads 0x80 whenever the output is low.
- R8: While an output is high and not yet acknowledged, the output and its active number do not change. This holds even if a better line becomes pending or the winning line goes away.
- R9: Writing bit 0 of the control word at 0x48 acknowledges the normal output, and bit 1 acknowledges the fast output. The acknowledged output is low after that edge and may rise again at the next edge. The other output is not affected.
- R10: Writing bit 1 of the config word at 0x10 starts a soft reset that restores the R2 state one edge later. Bit 0 of the status word at 0x14 reads 0 while the reset is in progress and 1 otherwise.
- R11: Line n belongs to group n>>5 and occupies bit n&31 in it. Group g's words start at 0x80 + 0x20*g. The word at +0x00 reads the raw inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| irq_in | input | NUM_SRC | Level-sensitive interrupt lines |
| irq_nrm_o | output | 1 | Normal interrupt output |
| irq_fst_o | output | 1 | Fast interrupt output |

## Verification
The arbiter is driven with pairs of software-triggered lines. The pairs include a clear priority winner, an equal-priority tie, lines split across both outputs, lines in different groups and lines at the extreme priority values. A wrong comparison direction, a lost tie-break or a crossed route each shows up as a different winner. Directed sequences follow:
- a raw input is first masked and then unmasked;
- a better line arrives while the output is held, so an output that re-arbitrates too early is exposed;
- each acknowledge bit is written alone, so one that clears both outputs is caught;
- a soft reset is issued while a line is asserted.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt controller: bus address map and the
// word selector used inside each 32-line group.
package irqc_pkg;
    localparam int ADDR_W = 10;
    localparam int GRP_W  = 32;

    localparam logic [ADDR_W-1:0] A_REV      = 10'h000;
    localparam logic [ADDR_W-1:0] A_SYSCFG   = 10'h010;
    localparam logic [ADDR_W-1:0] A_SYSSTAT  = 10'h014;
    localparam logic [ADDR_W-1:0] A_ACT_NRM  = 10'h040;
    localparam logic [ADDR_W-1:0] A_ACT_FST  = 10'h044;
    localparam logic [ADDR_W-1:0] A_CTRL     = 10'h048;
    localparam logic [ADDR_W-1:0] A_GRP_BASE = 10'h080;
    localparam logic [ADDR_W-1:0] A_LVL_BASE = 10'h100;

    // Word position inside a group, taken from address bits 4:2.
    typedef enum logic [2:0] {
        GW_RAW  = 3'd0,
        GW_MASK = 3'd1,
        GW_MCLR = 3'd2,
        GW_MSET = 3'd3,
        GW_TSET = 3'd4,
        GW_TCLR = 3'd5,
        GW_PNRM = 3'd6,
        GW_PFST = 3'd7
    } grp_word_e;
endpackage

// File: rtl/irqc_group.sv
`timescale 1ns/1ps
// One group of 32 lines: holds the mask and software-trigger bits.
// Assumes the parent has already decided that the write targets this group.
module irqc_group
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  grp_word_e        word,
    input  logic [GRP_W-1:0] wdata,
    output logic [GRP_W-1:0] mask_q,
    output logic [GRP_W-1:0] trig_q
);
    // Update mask and trigger bits from direct, set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask_q <= '1;
            trig_q <= '0;
        end else if (wr_en) begin
            case (word)
                GW_MASK: mask_q <= wdata;
                GW_MCLR: mask_q <= mask_q & ~wdata;
                GW_MSET: mask_q <= mask_q | wdata;
                GW_TSET: trig_q <= trig_q | wdata;
                GW_TCLR: trig_q <= trig_q & ~wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
// Combinational winner search: the smallest priority value wins, and the
// lowest line number wins among equals. Assumes pend is already masked and
// routed.
module irqc_arbiter #(
    parameter int NUM_SRC = 96,
    parameter int PRIO_W  = 6,
    parameter int ID_W    = 7
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      win_vld,
    output logic [ID_W-1:0]           win_id
);
    logic [PRIO_W-1:0] best;

    // Scan upward; a strict less-than keeps the earlier line on ties.
    always_comb begin
        win_vld = 1'b0;
        win_id  = '0;
        best    = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (!win_vld || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
                win_vld = 1'b1;
                win_id  = ID_W'(i);
                best    = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irqc_hold.sv
`timescale 1ns/1ps
// Output holder for one interrupt output. It latches the winner while idle
// and keeps it until acknowledged. If an acknowledge and a capture fall in
// the same cycle, the acknowledge wins.
module irqc_hold #(
    parameter int ID_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            ack,
    input  logic            win_vld,
    input  logic [ID_W-1:0] win_id,
    output logic            line_q,
    output logic [ID_W-1:0] id_q
);
    // Capture while idle, freeze while high, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            line_q <= 1'b0;
            id_q   <= '0;
        end else if (ack) begin
            line_q <= 1'b0;
        end else if (!line_q && win_vld) begin
            line_q <= 1'b1;
            id_q   <= win_id;
        end
    end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
// Prioritised interrupt controller top: bus decode, per-line level words,
// one group block per 32 lines, and one arbiter plus holder per output.
// Assumes word-aligned bus addresses and NUM_SRC a multiple of 32, up to 128.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int         NUM_SRC   = 96,
    parameter int         PRIO_W    = 6,
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               irq_nrm_o,
    output logic               irq_fst_o
);
    localparam int NGRP  = NUM_SRC / GRP_W;
    localparam int ID_W  = $clog2(NUM_SRC);
    localparam int GSEL_W = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam logic [ADDR_W-1:0] GRP_END = A_GRP_BASE + ADDR_W'(NGRP * 32);
    localparam logic [ADDR_W-1:0] LVL_END = A_LVL_BASE + ADDR_W'(NUM_SRC * 4);

    logic                      wr;
    logic                      in_grp;
    logic                      in_lvl;
    logic [GSEL_W-1:0]         grp_sel;
    grp_word_e                 grp_word;
    logic [ID_W-1:0]           lvl_idx;
    logic                      srst_q;
    logic                      ack_nrm;
    logic                      ack_fst;
    logic [NUM_SRC-1:0]        mask_all;
    logic [NUM_SRC-1:0]        trig_all;
    logic [NUM_SRC-1:0]        route_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        pend_any;
    logic [NUM_SRC-1:0]        pend_nrm;
    logic [NUM_SRC-1:0]        pend_fst;
    logic                      nrm_vld;
    logic                      fst_vld;
    logic [ID_W-1:0]           nrm_win;
    logic [ID_W-1:0]           fst_win;
    logic [ID_W-1:0]           nrm_id_q;
    logic [ID_W-1:0]           fst_id_q;

    // Address decode for the group and level regions and the control strobes.
    always_comb begin
        wr       = bus_sel && bus_wr;
        in_grp   = (bus_addr >= A_GRP_BASE) && (bus_addr < GRP_END);
        in_lvl   = (bus_addr >= A_LVL_BASE) && (bus_addr < LVL_END);
        grp_sel  = GSEL_W'((bus_addr - A_GRP_BASE) >> 5);
        grp_word = grp_word_e'(bus_addr[4:2]);
        lvl_idx  = ID_W'((bus_addr - A_LVL_BASE) >> 2);
        ack_nrm  = wr && (bus_addr == A_CTRL) && bus_wdata[0];
        ack_fst  = wr && (bus_addr == A_CTRL) && bus_wdata[1];
    end

    // Soft-reset pulse: one cycle long, and it clears all state at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= wr && (bus_addr == A_SYSCFG) && bus_wdata[1];
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        irqc_group u_group (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (srst_q),
            .wr_en  (wr && in_grp && (grp_sel == GSEL_W'(g))),
            .word   (grp_word),
            .wdata  (bus_wdata),
            .mask_q (mask_all[g*GRP_W +: GRP_W]),
            .trig_q (trig_all[g*GRP_W +: GRP_W])
        );
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_lvl
        logic [PRIO_W-1:0] prio_r;
        logic              route_r;
        // Per-line level word: the routing bit and the priority field.
        always_ff @(posedge clk) begin
            if (!rst_n || srst_q) begin
                prio_r  <= '0;
                route_r <= 1'b0;
            end else if (wr && in_lvl && (lvl_idx == ID_W'(n))) begin
                prio_r  <= bus_wdata[2 +: PRIO_W];
                route_r <= bus_wdata[0];
            end
        end
        assign prio_flat[n*PRIO_W +: PRIO_W] = prio_r;
        assign route_q[n]                    = route_r;
    end

    assign pend_any = (irq_in | trig_all) & ~mask_all;
    assign pend_nrm = pend_any & ~route_q;
    assign pend_fst = pend_any & route_q;

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb_nrm (
        .pend(pend_nrm), .prio_flat(prio_flat), .win_vld(nrm_vld), .win_id(nrm_win)
    );
    irqc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb_fst (
        .pend(pend_fst), .prio_flat(prio_flat), .win_vld(fst_vld), .win_id(fst_win)
    );

    irqc_hold #(.ID_W(ID_W)) u_hold_nrm (
        .clk(clk), .rst_n(rst_n), .clr(srst_q), .ack(ack_nrm),
        .win_vld(nrm_vld), .win_id(nrm_win), .line_q(irq_nrm_o), .id_q(nrm_id_q)
    );
    irqc_hold #(.ID_W(ID_W)) u_hold_fst (
        .clk(clk), .rst_n(rst_n), .clr(srst_q), .ack(ack_fst),
        .win_vld(fst_vld), .win_id(fst_win), .line_q(irq_fst_o), .id_q(fst_id_q)
    );

    // Read-data multiplexer; the value follows bus_addr combinationally.
    always_comb begin
        bus_rdata = '0;
        if (in_grp) begin
            case (grp_word)
                GW_RAW:           bus_rdata = irq_in[grp_sel*GRP_W +: GRP_W];
                GW_MASK:          bus_rdata = mask_all[grp_sel*GRP_W +: GRP_W];
                GW_TSET, GW_TCLR: bus_rdata = trig_all[grp_sel*GRP_W +: GRP_W];
                GW_PNRM:          bus_rdata = pend_nrm[grp_sel*GRP_W +: GRP_W];
                GW_PFST:          bus_rdata = pend_fst[grp_sel*GRP_W +: GRP_W];
                default:          bus_rdata = '0;
            endcase
        end else if (in_lvl) begin
            bus_rdata[2 +: PRIO_W] = prio_flat[lvl_idx*PRIO_W +: PRIO_W];
            bus_rdata[0]           = route_q[lvl_idx];
        end else begin
            case (bus_addr)
                A_REV:     bus_rdata[7:0] = {REV_MAJOR, REV_MINOR};
                A_SYSSTAT: bus_rdata[0]   = ~srst_q;
                A_ACT_NRM: begin
                    if (irq_nrm_o) bus_rdata[ID_W-1:0] = nrm_id_q;
                    else           bus_rdata[7]        = 1'b1;
                end
                A_ACT_FST: begin
                    if (irq_fst_o) bus_rdata[ID_W-1:0] = fst_id_q;
                    else           bus_rdata[7]        = 1'b1;
                end
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
// Assertion checker for irqc_top. It recomputes the acknowledge strobes from
// the bus and checks the hold, acknowledge and routing rules over time.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [1:0]         ctl_bits,
    input logic               irq_nrm_o,
    input logic               irq_fst_o,
    input logic               srst_q,
    input logic [NUM_SRC-1:0] pend_nrm,
    input logic [NUM_SRC-1:0] pend_fst,
    input logic [ID_W-1:0]    nrm_id_q,
    input logic [ID_W-1:0]    fst_id_q
);
    logic               ak_n;
    logic               ak_f;
    logic [NUM_SRC-1:0] pn_d;
    logic [NUM_SRC-1:0] pf_d;

    // Acknowledge strobes decoded independently from the bus pins.
    always_comb begin
        ak_n = bus_sel && bus_wr && (bus_addr == A_CTRL) && ctl_bits[0];
        ak_f = bus_sel && bus_wr && (bus_addr == A_CTRL) && ctl_bits[1];
    end

    // Delayed copies of the pending vectors, to compare against a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pn_d <= '0;
            pf_d <= '0;
        end else begin
            pn_d <= pend_nrm;
            pf_d <= pend_fst;
        end
    end

    a_r8_nrm_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_nrm_o && !ak_n && !srst_q) |=> (irq_nrm_o && nrm_id_q == $past(nrm_id_q)));
    a_r8_fst_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fst_o && !ak_f && !srst_q) |=> (irq_fst_o && fst_id_q == $past(fst_id_q)));
    a_r9_nrm_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_nrm_o && ak_n) |=> !irq_nrm_o);
    a_r9_fst_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fst_o && ak_f) |=> !irq_fst_o);
    a_r7_nrm_rise_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_nrm_o) |-> pn_d[nrm_id_q]);
    a_r5_fst_rise_routed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_fst_o) |-> pf_d[fst_id_q]);
    a_r10_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (!irq_nrm_o && !irq_fst_o));
endmodule

bind irqc_top irqc_checker #(.NUM_SRC(NUM_SRC)) u_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ctl_bits  (bus_wdata[1:0]),
    .irq_nrm_o (irq_nrm_o),
    .irq_fst_o (irq_fst_o),
    .srst_q    (srst_q),
    .pend_nrm  (pend_nrm),
    .pend_fst  (pend_fst),
    .nrm_id_q  (nrm_id_q),
    .fst_id_q  (fst_id_q)
);

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
// Bench for irqc_top: a table of arbitration pairs, then directed tests.
module irqc_top_bench;
    localparam int N = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          irq_nrm_o;
    logic          irq_fst_o;
    int            n_run = 0;
    int            n_fail = 0;

    irqc_top u_irqc_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_nrm_o(irq_nrm_o), .irq_fst_o(irq_fst_o)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [6:0] sa; logic [5:0] pa; logic ra;
        logic [6:0] sb; logic [5:0] pb; logic rb;
        logic [7:0] en; logic [7:0] ef;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{7'd5,  6'd10, 1'b0, 7'd40, 6'd3,  1'b0, 8'h28, 8'h80},
        '{7'd5,  6'd7,  1'b0, 7'd3,  6'd7,  1'b0, 8'h03, 8'h80},
        '{7'd70, 6'd0,  1'b1, 7'd2,  6'd1,  1'b0, 8'h02, 8'h46},
        '{7'd95, 6'd63, 1'b1, 7'd64, 6'd63, 1'b1, 8'h80, 8'h40},
        '{7'd33, 6'd20, 1'b0, 7'd31, 6'd21, 1'b0, 8'h21, 8'h80},
        '{7'd0,  6'd63, 1'b0, 7'd94, 6'd62, 1'b1, 8'h00, 8'h5E}
    };

    function automatic logic [9:0] ga(input int g, input int w);
        return 10'(128 + 32 * g + 4 * w);
    endfunction
    function automatic logic [9:0] la(input int n);
        return 10'(256 + 4 * n);
    endfunction

    task automatic wr32(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rdchk(input string tag, input logic [9:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1;
        chk(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table: arbitration pairs (R6 winner choice, R5 routing, R11 groups)
        foreach (VECS[k]) begin
            wr32(10'h010, 32'h2);
            @(negedge clk);
            wr32(la(VECS[k].sa), 32'({VECS[k].pa, 1'b0, VECS[k].ra}));
            wr32(la(VECS[k].sb), 32'({VECS[k].pb, 1'b0, VECS[k].rb}));
            wr32(ga(VECS[k].sa >> 5, 4), 32'h1 << (VECS[k].sa & 31));
            wr32(ga(VECS[k].sb >> 5, 4), 32'h1 << (VECS[k].sb & 31));
            wr32(ga(VECS[k].sa >> 5, 2), 32'h1 << (VECS[k].sa & 31));
            wr32(ga(VECS[k].sb >> 5, 2), 32'h1 << (VECS[k].sb & 31));
            wr32(10'h048, 32'h3);
            rdchk($sformatf("R6 vec%0d normal", k), 10'h040, 32'(VECS[k].en));
            rdchk($sformatf("R5 vec%0d fast", k), 10'h044, 32'(VECS[k].ef));
        end

        // Hard reset, then the reset state (R1, R2)
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rdchk("R1 revision", 10'h000, 32'h21);
        rdchk("R2 mask g0", ga(0, 1), 32'hFFFF_FFFF);
        rdchk("R2 mask g2", ga(2, 1), 32'hFFFF_FFFF);
        rdchk("R2 level 77", la(77), 32'h0);
        rdchk("R2 trig g1", ga(1, 4), 32'h0);
        rdchk("R2 act normal", 10'h040, 32'h80);
        rdchk("R2 act fast", 10'h044, 32'h80);
        chk("R2 outputs low", {30'b0, irq_nrm_o, irq_fst_o}, 32'h0);

        // Masking (R3), raw readback (R11), capture (R7)
        @(negedge clk); irq_in[10] = 1'b1;
        rdchk("R11 raw g0", ga(0, 0), 32'h400);
        rdchk("R3 masked pend", ga(0, 6), 32'h0);
        chk("R3 masked no output", 32'(irq_nrm_o), 32'h0);
        wr32(ga(0, 2), 32'h400);
        rdchk("R3 unmasked pend", ga(0, 6), 32'h400);
        chk("R7 output high", 32'(irq_nrm_o), 32'h1);
        rdchk("R7 act id", 10'h040, 32'h0A);

        // Hold while a better line arrives and the winner drops (R8)
        wr32(ga(0, 4), 32'h8);
        wr32(ga(0, 2), 32'h8);
        @(negedge clk); irq_in[10] = 1'b0;
        rdchk("R8 held id", 10'h040, 32'h0A);
        chk("R8 line held", 32'(irq_nrm_o), 32'h1);

        // Acknowledge and re-arm (R9)
        wr32(10'h048, 32'h1);
        chk("R9 drop after ack", 32'(irq_nrm_o), 32'h0);
        rdchk("R9 re-armed id", 10'h040, 32'h03);

        // Software trigger clear (R4)
        wr32(ga(0, 5), 32'h8);
        rdchk("R4 trig cleared", ga(0, 4), 32'h0);
        rdchk("R4 pend gone", ga(0, 6), 32'h0);
        wr32(10'h048, 32'h1);
        rdchk("R7 spurious", 10'h040, 32'h80);

        // Mask set alias and direct mask write (R3)
        wr32(ga(0, 3), 32'h8);
        rdchk("R3 mask set alias", ga(0, 1), 32'hFFFF_FBFF);
        wr32(ga(2, 1), 32'h0000_00F0);
        rdchk("R3 mask direct", ga(2, 1), 32'h0000_00F0);

        // Fast routing and separate acknowledge bits (R5, R9)
        wr32(la(70), 32'h15);
        rdchk("R5 level readback", la(70), 32'h15);
        wr32(ga(2, 1), 32'h0);
        @(negedge clk); irq_in[70] = 1'b1;
        rdchk("R5 fast pend", ga(2, 7), 32'h40);
        rdchk("R5 normal pend empty", ga(2, 6), 32'h0);
        rdchk("R5 act fast", 10'h044, 32'h46);
        chk("R5 normal stays low", 32'(irq_nrm_o), 32'h0);
        wr32(10'h048, 32'h1);
        chk("R9 normal ack spares fast", 32'(irq_fst_o), 32'h1);
        wr32(10'h048, 32'h2);
        chk("R9 fast ack drops", 32'(irq_fst_o), 32'h0);
        rdchk("R9 fast re-armed", 10'h044, 32'h46);

        // Soft reset while a line is asserted (R10)
        wr32(10'h010, 32'h2);
        bus_addr = 10'h014; #1;
        chk("R10 busy status", bus_rdata, 32'h0);
        rdchk("R10 done status", 10'h014, 32'h1);
        rdchk("R10 mask restored", ga(2, 1), 32'hFFFF_FFFF);
        rdchk("R10 level cleared", la(70), 32'h0);
        chk("R10 outputs low", {30'b0, irq_nrm_o, irq_fst_o}, 32'h0);
        @(negedge clk); irq_in = '0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule